// File: doc/BRIEF.md
# Bank-Switchable Dual-Port Memory Router

This block places one memory, made of four equal banks, between two independent requesters called the left port and the right port. A four-bit ownership input, one bit per bank, is driven from outside the block and decides which port may use each bank. Each port issues at most one access per clock. An access names a bank, a word inside that bank, a direction, two byte enables and, for a write, a 16-bit data word. The block carries out the access only when the issuing port owns the addressed bank. A write to a bank the port does not own is dropped. A read of such a bank returns a fixed filler word.

Ownership is exclusive, so the two ports never meet in the same bank, and no arbitration is needed. Both ports can work in different banks in the same cycle at full rate. The request side uses a plain enable as its valid and has no ready signal, so the block never applies back-pressure. On the read side, `x_rvalid` rises for exactly one cycle, one clock after each read request, and the port must take the data in that cycle because nothing is held back. The ownership inputs should only move while neither port is writing. The block raises a one-cycle flag when they move during an enabled write.

The word address width is the parameter `ADDR_W`. The full-size bank of 16K words uses `ADDR_W = 14`. The default of 8 keeps elaboration small.

Top module: `dual_bank_router`

## Requirements
- R1: The memory has four banks, chosen by the two-bit bank field, each holding 2^ADDR_W 16-bit words chosen by the word address. A word written to one bank and address reads back unchanged, and the same address in another bank is a separate word.
- R2: Bank b belongs to the left port while `own_left[b]` is 1 and to the right port while it is 0.
- R3: Any mix of ownership is legal, including all four banks given to one port and none to the other.
- R4: A write by a port to a bank it does not own leaves every memory word unchanged.
- R5: A read by a port of a bank it does not own still produces `x_rvalid`, with `x_rdata` equal to 16'hDEAD.
- R6: On a write, `x_be[1]` enables data bits 15:8 and `x_be[0]` enables bits 7:0. Each byte whose enable is 0 keeps its old contents.
- R7: Accesses by the two ports to different banks in the same cycle both complete with no effect on each other.
- R8: A read request (`x_en`=1, `x_we`=0) is answered on the next clock edge: `x_rvalid` is 1 for that one cycle, and `x_rdata` holds the word as it stood before that edge.
- R9: After a cycle with `x_en`=0 or with a write, the port shows `x_rvalid`=0 and `x_rdata`=0 in the next cycle.
- R10: `sel_err` is 1 for one cycle after a clock edge at which `own_left` differs from its value at the previous edge while either port has `x_en`=1 and `x_we`=1. Otherwise it is 0. A change with no enabled write does not set it.
- R11: While and just after reset, `l_rvalid`, `r_rvalid`, `l_rdata`, `r_rdata` and `sel_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| own_left | input | 4 | Per-bank owner: 1 gives the bank to the left port, 0 to the right |
| l_en | input | 1 | Left request enable (valid) |
| l_we | input | 1 | Left direction: 1 write, 0 read |
| l_bank | input | 2 | Left bank field |
| l_addr | input | ADDR_W | Left word address |
| l_be | input | 2 | Left byte enables, bit 1 upper byte |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data, zero when not valid |
| l_rvalid | output | 1 | Left read response valid |
| r_en | input | 1 | Right request enable (valid) |
| r_we | input | 1 | Right direction: 1 write, 0 read |
| r_bank | input | 2 | Right bank field |
| r_addr | input | ADDR_W | Right word address |
| r_be | input | 2 | Right byte enables, bit 1 upper byte |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data, zero when not valid |
| r_rvalid | output | 1 | Right read response valid |
| sel_err | output | 1 | Ownership changed during an enabled write |

## Verification
The bench targets several corner cases, and each one shows a typical fault in a clear way:
- **Writes to banks the port does not own.** A router that ignores ownership on the write path would corrupt the owner's data. A later read by the owner shows this.
- **Reads of foreign banks.** A design that returns the bank's real contents instead of the filler word fails here.
- **Partial byte enables.** A swapped or ignored enable shows up as a wrong byte on read-back.
- **Same-cycle traffic from both ports in different banks.** A shared data path would make one port lose its access.
- **Ownership moves with and without a write in flight.** This catches a flag that fires on every change, and also one that never fires.

// File: rtl/dual_bank_router_pkg.sv
package dual_bank_router_pkg;

  localparam int unsigned DATA_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BE_W   = DATA_W / BYTE_W;

  // Word returned when a port reads a bank owned by the other side.
  localparam logic [DATA_W-1:0] FOREIGN_WORD = 16'hDEAD;

  function automatic logic [DATA_W-1:0] byte_merge(
    input logic [DATA_W-1:0] old_w,
    input logic [DATA_W-1:0] new_w,
    input logic [BE_W-1:0]   be
  );
    logic [DATA_W-1:0] res;
    res = old_w;
    for (int i = 0; i < int'(BE_W); i++) begin
      if (be[i]) res[i*BYTE_W +: BYTE_W] = new_w[i*BYTE_W +: BYTE_W];
    end
    return res;
  endfunction

endpackage

// File: rtl/dual_bank_router_port.sv
module dual_bank_router_port
  import dual_bank_router_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BANK_W = 2,
  localparam int unsigned NBANK = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBANK-1:0]  owns,
  input  logic              en,
  input  logic              we,
  input  logic [BANK_W-1:0] bank,
  input  logic [DATA_W-1:0] bank_rd [NBANK],
  output logic [NBANK-1:0]  wr_hit,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic              rvalid_q;
  logic              owned_q;
  logic [BANK_W-1:0] bank_q;
  logic              past_ok;

  // Per-bank write strobe: only toward a bank this port owns.
  for (genvar b = 0; b < int'(NBANK); b++) begin : g_hit
    assign wr_hit[b] = en && we && (bank == BANK_W'(b)) && owns[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      owned_q  <= 1'b0;
      bank_q   <= '0;
      past_ok  <= 1'b0;
    end else begin
      rvalid_q <= en && !we;
      owned_q  <= owns[bank];
      bank_q   <= bank;
      past_ok  <= 1'b1;
    end
  end

  always_comb begin
    if (!rvalid_q)     rdata = '0;
    else if (owned_q)  rdata = bank_rd[bank_q];
    else               rdata = FOREIGN_WORD;
  end

  assign rvalid = rvalid_q;

  // R8
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (rvalid == $past(en && !we)));

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || we) |=> (rdata == '0));

  // R1
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));

endmodule

// File: rtl/dual_bank_router_bank.sv
module dual_bank_router_bank
  import dual_bank_router_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              sel_left,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [BE_W-1:0]   l_be,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic              r_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [BE_W-1:0]   r_be,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] rd_q
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              wr;
  logic [ADDR_W-1:0] addr;
  logic [BE_W-1:0]   be;
  logic [DATA_W-1:0] wd;

  // Owner mux: the owning side alone drives this bank.
  always_comb begin
    if (sel_left) begin
      wr = l_wr; addr = l_addr; be = l_be; wd = l_wdata;
    end else begin
      wr = r_wr; addr = r_addr; be = r_be; wd = r_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (wr) mem[addr] <= byte_merge(mem[addr], wd, be);
    rd_q <= mem[addr];
  end

endmodule

// File: rtl/dual_bank_router_selguard.sv
module dual_bank_router_selguard #(
  parameter int unsigned NBANK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBANK-1:0] own,
  input  logic             wr_any,
  output logic             err
);

  logic [NBANK-1:0] own_q;
  logic             err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q <= own;
      err_q <= 1'b0;
    end else begin
      own_q <= own;
      err_q <= (own != own_q) && wr_any;
    end
  end

  assign err = err_q;

endmodule

// File: rtl/dual_bank_router.sv
module dual_bank_router
  import dual_bank_router_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BANK_W = 2,
  localparam int unsigned NBANK = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBANK-1:0]  own_left,
  input  logic              l_en,
  input  logic              l_we,
  input  logic [BANK_W-1:0] l_bank,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [1:0]        l_be,
  input  logic [15:0]       l_wdata,
  output logic [15:0]       l_rdata,
  output logic              l_rvalid,
  input  logic              r_en,
  input  logic              r_we,
  input  logic [BANK_W-1:0] r_bank,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [1:0]        r_be,
  input  logic [15:0]       r_wdata,
  output logic [15:0]       r_rdata,
  output logic              r_rvalid,
  output logic              sel_err
);

  logic [NBANK-1:0]  l_hit;
  logic [NBANK-1:0]  r_hit;
  logic [NBANK-1:0]  own_right;
  logic [DATA_W-1:0] bank_rd [NBANK];

  assign own_right = ~own_left;

  dual_bank_router_port #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_lport (
    .clk(clk), .rst_n(rst_n), .owns(own_left),
    .en(l_en), .we(l_we), .bank(l_bank), .bank_rd(bank_rd),
    .wr_hit(l_hit), .rdata(l_rdata), .rvalid(l_rvalid)
  );

  dual_bank_router_port #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_rport (
    .clk(clk), .rst_n(rst_n), .owns(own_right),
    .en(r_en), .we(r_we), .bank(r_bank), .bank_rd(bank_rd),
    .wr_hit(r_hit), .rdata(r_rdata), .rvalid(r_rvalid)
  );

  for (genvar b = 0; b < int'(NBANK); b++) begin : g_bank
    dual_bank_router_bank #(.ADDR_W(ADDR_W)) u_bank (
      .clk(clk), .sel_left(own_left[b]),
      .l_wr(l_hit[b]), .l_addr(l_addr), .l_be(l_be), .l_wdata(l_wdata),
      .r_wr(r_hit[b]), .r_addr(r_addr), .r_be(r_be), .r_wdata(r_wdata),
      .rd_q(bank_rd[b])
    );

    // R2
    left_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      l_hit[b] |-> own_left[b]);

    // R4
    right_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      r_hit[b] |-> !own_left[b]);

    // R7
    no_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(l_hit[b] && r_hit[b]));
  end

  dual_bank_router_selguard #(.NBANK(NBANK)) u_guard (
    .clk(clk), .rst_n(rst_n), .own(own_left),
    .wr_any((l_en && l_we) || (r_en && r_we)),
    .err(sel_err)
  );

  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |-> $past((l_en && l_we) || (r_en && r_we)));

endmodule

// File: tb/dual_bank_router_tb.sv
`timescale 1ns/100ps
module dual_bank_router_tb;

  localparam int ADDR_W = 8;
  localparam int NB     = 4;
  localparam int DEPTH  = 256;
  localparam logic [15:0] FILL = 16'hDEAD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] own_left = 4'b0011;
  logic l_en = 0, l_we = 0, r_en = 0, r_we = 0;
  logic [1:0] l_bank = 0, r_bank = 0, l_be = 0, r_be = 0;
  logic [ADDR_W-1:0] l_addr = 0, r_addr = 0;
  logic [15:0] l_wdata = 0, r_wdata = 0;
  logic [15:0] l_rdata, r_rdata;
  logic l_rvalid, r_rvalid, sel_err;

  always #2.5 clk = ~clk;

  dual_bank_router #(.ADDR_W(ADDR_W), .BANK_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .own_left(own_left),
    .l_en(l_en), .l_we(l_we), .l_bank(l_bank), .l_addr(l_addr), .l_be(l_be),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rvalid(l_rvalid),
    .r_en(r_en), .r_we(r_we), .r_bank(r_bank), .r_addr(r_addr), .r_be(r_be),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rvalid(r_rvalid),
    .sel_err(sel_err)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] mdl [NB][DEPTH];
  logic [3:0]  own_prev;
  logic        e_lv, e_rv, e_err;
  logic [15:0] e_ld, e_rd;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] merge(logic [15:0] o, logic [15:0] n, logic [1:0] be);
    logic [15:0] r;
    r = o;
    if (be[0]) r[7:0]  = n[7:0];
    if (be[1]) r[15:8] = n[15:8];
    return r;
  endfunction

  function automatic logic [15:0] init_word(int b, int a);
    return 16'hA000 | 16'(b << 8) | 16'(a);
  endfunction

  // Model one cycle, let one edge pass, compare at the following negedge.
  task automatic step();
    logic lo, ro;
    lo = own_left[l_bank];
    ro = !own_left[r_bank];
    e_lv = l_en && !l_we;
    e_rv = r_en && !r_we;
    e_ld = !e_lv ? 16'h0 : (lo ? mdl[l_bank][l_addr] : FILL);
    e_rd = !e_rv ? 16'h0 : (ro ? mdl[r_bank][r_addr] : FILL);
    if (l_en && l_we && lo) mdl[l_bank][l_addr] = merge(mdl[l_bank][l_addr], l_wdata, l_be);
    if (r_en && r_we && ro) mdl[r_bank][r_addr] = merge(mdl[r_bank][r_addr], r_wdata, r_be);
    e_err = (own_left != own_prev) && ((l_en && l_we) || (r_en && r_we));
    own_prev = own_left;
    @(negedge clk);
    chk("R8/R9 left rvalid",  16'(l_rvalid), 16'(e_lv));
    chk("R1/R5 left rdata",   l_rdata, e_ld);
    chk("R8/R9 right rvalid", 16'(r_rvalid), 16'(e_rv));
    chk("R1/R5 right rdata",  r_rdata, e_rd);
    chk("R10 sel_err",        16'(sel_err), 16'(e_err));
  endtask

  task automatic lop(logic en, logic we, logic [1:0] b, logic [ADDR_W-1:0] a,
                     logic [1:0] be, logic [15:0] d);
    l_en = en; l_we = we; l_bank = b; l_addr = a; l_be = be; l_wdata = d;
  endtask

  task automatic rop(logic en, logic we, logic [1:0] b, logic [ADDR_W-1:0] a,
                     logic [1:0] be, logic [15:0] d);
    r_en = en; r_we = we; r_bank = b; r_addr = a; r_be = be; r_wdata = d;
  endtask

  task automatic idle();
    lop(0, 0, 0, 0, 0, 0);
    rop(0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: outputs quiet in reset
    chk("R11 l_rvalid", 16'(l_rvalid), 16'h0);
    chk("R11 l_rdata",  l_rdata, 16'h0);
    chk("R11 r_rvalid", 16'(r_rvalid), 16'h0);
    chk("R11 r_rdata",  r_rdata, 16'h0);
    chk("R11 sel_err",  16'(sel_err), 16'h0);
    own_prev = own_left;
    rst_n = 1'b1;

    // Fill every word: left owns banks 0,1 and right owns 2,3 (R2, R7)
    for (int a = 0; a < DEPTH; a++) begin
      for (int b = 0; b < 2; b++) begin
        lop(1, 1, 2'(b), ADDR_W'(a), 2'b11, init_word(b, a));
        rop(1, 1, 2'(b + 2), ADDR_W'(a), 2'b11, init_word(b + 2, a));
        step();
      end
    end

    // R3: all banks to the left, changed with no write in flight
    idle(); own_left = 4'b1111; step();
    chk("R10 quiet change", 16'(sel_err), 16'h0);
    lop(1, 0, 3, 7, 0, 0); rop(1, 0, 3, 7, 0, 0); step();
    chk("R3 left reads bank3", l_rdata, init_word(3, 7));
    chk("R5 right foreign read", r_rdata, FILL);
    chk("R5 right rvalid", 16'(r_rvalid), 16'h1);

    // R4: right writes a bank it does not own
    idle(); rop(1, 1, 0, 9, 2'b11, 16'h1234); step();
    idle(); lop(1, 0, 0, 9, 0, 0); step();
    chk("R4 dropped write", l_rdata, init_word(0, 9));

    // R3: all banks to the right
    idle(); own_left = 4'b0000; step();
    // R6: byte enables
    rop(1, 1, 2, 3, 2'b01, 16'h55AA); step();
    rop(1, 0, 2, 3, 0, 0); step();
    chk("R6 low byte", r_rdata, {init_word(2, 3)[15:8], 8'hAA});
    rop(1, 1, 2, 3, 2'b10, 16'h7700); step();
    rop(1, 1, 2, 3, 2'b00, 16'hFFFF); step();
    rop(1, 0, 2, 3, 0, 0); step();
    chk("R6 high byte", r_rdata, 16'h77AA);

    // R7: both ports in different banks in one cycle
    idle(); own_left = 4'b0101; step();
    lop(1, 1, 0, 20, 2'b11, 16'h1111); rop(1, 1, 1, 20, 2'b11, 16'h2222); step();
    lop(1, 0, 0, 20, 0, 0); rop(1, 0, 1, 20, 0, 0); step();
    chk("R7 left",  l_rdata, 16'h1111);
    chk("R7 right", r_rdata, 16'h2222);

    // R10: ownership moves during a left write
    idle(); own_left = 4'b1101; lop(1, 1, 0, 21, 2'b11, 16'h3333); step();
    chk("R10 flagged", 16'(sel_err), 16'h1);
    idle(); step();
    chk("R10 one cycle", 16'(sel_err), 16'h0);
    // R9: idle and write cycles give zero data
    chk("R9 idle rdata", l_rdata, 16'h0);
    chk("R9 idle rvalid", 16'(r_rvalid), 16'h0);

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0) own_left = 4'($urandom);
      lop(1'($urandom), 1'($urandom), 2'($urandom), ADDR_W'($urandom),
          2'($urandom), 16'($urandom));
      rop(1'($urandom), 1'($urandom), 2'($urandom), ADDR_W'($urandom),
          2'($urandom), 16'($urandom));
      step();
    end

    done = 1;
    summary();
    $finish;
  end

endmodule